// File: doc/BRIEF.md
# Lockstep Alarm and Fault-Injection Controller

This block sits beside the comparator of a dual-core lockstep pair. It collects the per-slice mismatch flags into a sticky context vector. It derives a small alarm vector from those flags and from its own health checks. Each alarm is filtered through a per-alarm two-bit mask code and routed to one of four severity levels, and an interrupt request is driven whenever an active alarm sits at a severity that software has enabled. A supervising processor reaches all of this through a single-cycle word-addressed register port.

For self-test, software can raise any implemented alarm transparently, so the alarm follows the injection bit. It can also fire a root fault at a chosen comparator slice. A root fault is sticky until reset: it raises alarms 1, 2 and 4 and drives the comparator state into the fail state. The state moves from disabled to operational on an enable command, and a small budget limits how many enable commands may be issued before an alarm is raised.

Top module: `lockstep_alarm_ctrl`

## Requirements
- R1: After reset the block shows these values:
  - alarm output 0, state 0x1, slice context 0, irq 0
  - mask A and mask B 0x555555
  - severity A 0xE8FCA8 and severity B 0xAA0000
  - remaining enable count 2
- R2: The state output is one-hot: 0x1 disabled, 0x2 operational, 0x4 fail. A write to the enable address moves disabled to operational. No other transition leaves the fail state.
- R3: Alarm injection is transparent. Bit k of the injection register drives alarm k only while it is set, and only for implemented positions 0-4, 16, 17 and 19. All other bits have no effect on the alarm output, and clearing the register leaves the state unchanged.
- R4: A write of 1 to bit 0 of the root-fault register fires a root fault, provided the root-slice select register holds a value below 23. The fault raises alarms 1, 2 and 4 and sets the state to 0x4. With a select value of 23 or above the write has no effect.
- R5: A root fault is sticky. Clearing the root-fault register leaves the alarms and the fail state in place until reset.
- R6: Bit i of the slice context register is set, and stays set, when mismatch input i is high while the state is operational. Alarm 0 is active whenever the context is nonzero. Mismatch inputs are ignored in the disabled and fail states, and a root fault sets no context bit.
- R7: The mask field of alarm k is bits [2k+1:2k] of mask A for k<12, and bits [2(k-12)+1:2(k-12)] of mask B otherwise.
  - Code 01 lets the alarm through.
  - Code 10 masks it.
  - Codes 00 and 11 mask it and also raise alarm 19, which is itself subject to its own field.
- R8: The severity of alarm k is the two-bit field of the same position in severity A or B. The irq output is high exactly while some active alarm has severity s with bit s of the irq-config register set, and is low otherwise.
- R9: The enable budget allows 2+1 = 3 enable commands. The fourth and later commands raise alarm 17, which stays set until reset. Reading the enable address returns the remaining count, which falls 2, 1, 0 and never rises.
- R10: Register map by word address:
  - 0 alarms (read only)
  - 1 state (read only)
  - 2 slice context (read only)
  - 3 alarm injection
  - 4 root-fault control
  - 5 root-slice select
  - 6 mask A, 7 mask B
  - 8 severity A, 9 severity B
  - 10 irq config (4 bits)
  - 11 enable command / remaining count

  Read data appears on the cycle after rd_en. A write, a root fault or a mismatch pulse is visible on the alarm, state and irq outputs by the third rising edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_mm | input | 23 | Per-slice mismatch flags from the comparator |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| alarms | output | 32 | Active (unmasked) alarm vector |
| state | output | 3 | One-hot comparator state |
| slice_ctx | output | 23 | Sticky mismatch slice context |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- the state stays one-hot;
- the fail state is never left;
- the slice context does not move outside the operational state;
- the remaining enable count never rises;
- irq is never high with an empty alarm vector.

Only the bench scenarios can show the rest:
- the exact alarm patterns produced by each mask code;
- the irq response for every alarm against all sixteen irq-config values;
- the out-of-range slice select being ignored;
- root-fault stickiness after the control register is cleared;
- the point at which the enable budget runs out.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'b001,
    ST_RUN  = 3'b010,
    ST_FAIL = 3'b100
  } lsa_state_e;

  localparam int ADR_ALARM = 0;
  localparam int ADR_STATE = 1;
  localparam int ADR_CTX   = 2;
  localparam int ADR_INJ   = 3;
  localparam int ADR_ROOT  = 4;
  localparam int ADR_RSEL  = 5;
  localparam int ADR_MSKA  = 6;
  localparam int ADR_MSKB  = 7;
  localparam int ADR_SEVA  = 8;
  localparam int ADR_SEVB  = 9;
  localparam int ADR_IRQC  = 10;
  localparam int ADR_EN    = 11;

  localparam int ALM_MISMATCH = 0;
  localparam int ALM_ROOT_A   = 1;
  localparam int ALM_ROOT_B   = 2;
  localparam int ALM_ROOT_C   = 4;
  localparam int ALM_BUDGET   = 17;
  localparam int ALM_CFGERR   = 19;

  localparam logic [31:0] ALM_IMPL  = 32'h000B_001F;
  localparam logic [31:0] MASK_RST  = 32'h0055_5555;
  localparam logic [31:0] SEVA_RST  = 32'h00E8_FCA8;
  localparam logic [31:0] SEVB_RST  = 32'h00AA_0000;

endpackage

// File: rtl/lsa_regs.sv
module lsa_regs
  import lsa_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int FW     = 24,
  parameter int NSLICE = 23,
  parameter int SW     = 6,
  parameter int CW     = 4,
  parameter int NSEV   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     alarm_rb,
  input  logic [2:0]        state_rb,
  input  logic [NSLICE-1:0] ctx_rb,
  input  logic [CW-1:0]     rem_rb,
  output logic [DW-1:0]     inj_q,
  output logic              root_arm_q,
  output logic [SW-1:0]     root_sel_q,
  output logic [FW-1:0]     mask_a_q,
  output logic [FW-1:0]     mask_b_q,
  output logic [FW-1:0]     sev_a_q,
  output logic [FW-1:0]     sev_b_q,
  output logic [NSEV-1:0]   irqcfg_q,
  output logic              en_cmd
);

  logic [DW-1:0] rd_mux;

  assign en_cmd = wr_en && (int'(addr) == ADR_EN);

  always_ff @(posedge clk) begin
    if (rst) begin
      inj_q      <= '0;
      root_arm_q <= 1'b0;
      root_sel_q <= '0;
      mask_a_q   <= MASK_RST[FW-1:0];
      mask_b_q   <= MASK_RST[FW-1:0];
      sev_a_q    <= SEVA_RST[FW-1:0];
      sev_b_q    <= SEVB_RST[FW-1:0];
      irqcfg_q   <= '0;
    end else if (wr_en) begin
      case (int'(addr))
        ADR_INJ:  inj_q      <= wdata;
        ADR_ROOT: root_arm_q <= wdata[0];
        ADR_RSEL: root_sel_q <= wdata[SW-1:0];
        ADR_MSKA: mask_a_q   <= wdata[FW-1:0];
        ADR_MSKB: mask_b_q   <= wdata[FW-1:0];
        ADR_SEVA: sev_a_q    <= wdata[FW-1:0];
        ADR_SEVB: sev_b_q    <= wdata[FW-1:0];
        ADR_IRQC: irqcfg_q   <= wdata[NSEV-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(addr))
      ADR_ALARM: rd_mux = alarm_rb;
      ADR_STATE: rd_mux = DW'(state_rb);
      ADR_CTX:   rd_mux = DW'(ctx_rb);
      ADR_INJ:   rd_mux = inj_q;
      ADR_ROOT:  rd_mux = DW'(root_arm_q);
      ADR_RSEL:  rd_mux = DW'(root_sel_q);
      ADR_MSKA:  rd_mux = DW'(mask_a_q);
      ADR_MSKB:  rd_mux = DW'(mask_b_q);
      ADR_SEVA:  rd_mux = DW'(sev_a_q);
      ADR_SEVB:  rd_mux = DW'(sev_b_q);
      ADR_IRQC:  rd_mux = DW'(irqcfg_q);
      ADR_EN:    rd_mux = DW'(rem_rb);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/lsa_state.sv
module lsa_state
  import lsa_pkg::*;
#(
  parameter int NSLICE    = 23,
  parameter int SW        = 6,
  parameter int CW        = 4,
  parameter int EN_BUDGET = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_cmd,
  input  logic              root_arm,
  input  logic [SW-1:0]     root_sel,
  input  logic [NSLICE-1:0] slice_mm,
  output lsa_state_e        state_q,
  output logic [NSLICE-1:0] ctx_q,
  output logic              root_q,
  output logic              ovf_q,
  output logic [CW-1:0]     rem_q
);

  logic spent_q;
  logic root_hit;

  assign root_hit = root_arm && (int'(root_sel) < NSLICE);

  always_ff @(posedge clk) begin
    if (rst) begin
      root_q <= 1'b0;
    end else if (root_hit) begin
      root_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
    end else if (root_q) begin
      state_q <= ST_FAIL;
    end else if (en_cmd && state_q == ST_OFF) begin
      state_q <= ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q <= '0;
    end else if (state_q == ST_RUN) begin
      ctx_q <= ctx_q | slice_mm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= CW'(EN_BUDGET);
      spent_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (en_cmd) begin
      if (rem_q != '0) rem_q <= rem_q - 1'b1;
      else if (!spent_q) spent_q <= 1'b1;
      else ovf_q <= 1'b1;
    end
  end

  // R2
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  // R5
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_FAIL |=> state_q == ST_FAIL);

  // R6
  ctx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != ST_RUN |=> $stable(ctx_q));

  // R9
  rem_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rem_q <= $past(rem_q));

endmodule

// File: rtl/lsa_alarm_core.sv
module lsa_alarm_core
  import lsa_pkg::*;
#(
  parameter int NALARM = 24,
  parameter int NSEV   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NALARM-1:0] inj,
  input  logic              root_flt,
  input  logic              ctx_any,
  input  logic              budget_ovf,
  input  logic [NALARM-1:0] mask_a,
  input  logic [NALARM-1:0] mask_b,
  input  logic [NALARM-1:0] sev_a,
  input  logic [NALARM-1:0] sev_b,
  input  logic [NSEV-1:0]   irqcfg,
  output logic [NALARM-1:0] alarms_q,
  output logic              irq_q
);

  localparam int HALF = NALARM / 2;
  localparam int SVW  = $clog2(NSEV);

  logic [NALARM-1:0] pass_en;
  logic [NALARM-1:0] cfg_bad;
  logic [NALARM-1:0] sev_hit;
  logic [NALARM-1:0] raw;
  logic [NALARM-1:0] act;

  for (genvar k = 0; k < NALARM; k++) begin : g_alm
    logic [1:0]     mcode;
    logic [SVW-1:0] sev;
    if (k < HALF) begin : g_lo
      assign mcode = mask_a[2*k +: 2];
      assign sev   = sev_a[2*k +: SVW];
    end else begin : g_hi
      assign mcode = mask_b[2*(k-HALF) +: 2];
      assign sev   = sev_b[2*(k-HALF) +: SVW];
    end
    assign pass_en[k] = (mcode == 2'b01);
    assign cfg_bad[k] = (mcode == 2'b00) || (mcode == 2'b11);
    assign sev_hit[k] = irqcfg[sev];
  end

  always_comb begin
    raw = inj & ALM_IMPL[NALARM-1:0];
    raw[ALM_MISMATCH] = raw[ALM_MISMATCH] | ctx_any;
    raw[ALM_ROOT_A]   = raw[ALM_ROOT_A]   | root_flt;
    raw[ALM_ROOT_B]   = raw[ALM_ROOT_B]   | root_flt;
    raw[ALM_ROOT_C]   = raw[ALM_ROOT_C]   | root_flt;
    raw[ALM_BUDGET]   = raw[ALM_BUDGET]   | budget_ovf;
    raw[ALM_CFGERR]   = raw[ALM_CFGERR]   | (|cfg_bad);
    act = raw & pass_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarms_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      alarms_q <= act;
      irq_q    <= |(act & sev_hit);
    end
  end

  // R8
  irq_needs_alarm_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (alarms_q != '0));

  // R5
  root_alarms_chk: assert property (@(posedge clk) disable iff (rst)
    (root_flt && $past(root_flt) && pass_en[ALM_ROOT_A] && $past(pass_en[ALM_ROOT_A]))
      |-> alarms_q[ALM_ROOT_A]);

endmodule

// File: rtl/lockstep_alarm_ctrl.sv
module lockstep_alarm_ctrl
  import lsa_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 4,
  parameter int NSLICE    = 23,
  parameter int NALARM    = 24,
  parameter int NSEV      = 4,
  parameter int CW        = 4,
  parameter int EN_BUDGET = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSLICE-1:0] slice_mm,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     alarms,
  output logic [2:0]        state,
  output logic [NSLICE-1:0] slice_ctx,
  output logic              irq
);

  localparam int SW = $clog2(NSLICE) + 1;

  logic [DW-1:0]     inj_q;
  logic              root_arm_q;
  logic [SW-1:0]     root_sel_q;
  logic [NALARM-1:0] mask_a_q, mask_b_q, sev_a_q, sev_b_q;
  logic [NSEV-1:0]   irqcfg_q;
  logic              en_cmd;
  lsa_state_e        state_q;
  logic [NSLICE-1:0] ctx_q;
  logic              root_q, ovf_q;
  logic [CW-1:0]     rem_q;
  logic [NALARM-1:0] alarms_q;

  assign alarms    = DW'(alarms_q);
  assign state     = state_q;
  assign slice_ctx = ctx_q;

  lsa_regs #(
    .DW(DW), .AW(AW), .FW(NALARM), .NSLICE(NSLICE), .SW(SW), .CW(CW), .NSEV(NSEV)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .alarm_rb(alarms), .state_rb(state_q), .ctx_rb(ctx_q), .rem_rb(rem_q),
    .inj_q(inj_q), .root_arm_q(root_arm_q), .root_sel_q(root_sel_q),
    .mask_a_q(mask_a_q), .mask_b_q(mask_b_q), .sev_a_q(sev_a_q), .sev_b_q(sev_b_q),
    .irqcfg_q(irqcfg_q), .en_cmd(en_cmd)
  );

  lsa_state #(
    .NSLICE(NSLICE), .SW(SW), .CW(CW), .EN_BUDGET(EN_BUDGET)
  ) u_state (
    .clk(clk), .rst(rst), .en_cmd(en_cmd), .root_arm(root_arm_q),
    .root_sel(root_sel_q), .slice_mm(slice_mm), .state_q(state_q),
    .ctx_q(ctx_q), .root_q(root_q), .ovf_q(ovf_q), .rem_q(rem_q)
  );

  lsa_alarm_core #(
    .NALARM(NALARM), .NSEV(NSEV)
  ) u_alarm (
    .clk(clk), .rst(rst), .inj(inj_q[NALARM-1:0]), .root_flt(root_q),
    .ctx_any(|ctx_q), .budget_ovf(ovf_q),
    .mask_a(mask_a_q), .mask_b(mask_b_q), .sev_a(sev_a_q), .sev_b(sev_b_q),
    .irqcfg(irqcfg_q), .alarms_q(alarms_q), .irq_q(irq)
  );

endmodule

// File: tb/tb_lockstep_alarm_ctrl.sv
`timescale 1ns/1ps
module tb_lockstep_alarm_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] slice_mm = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, alarms;
  logic [2:0]  state;
  logic [22:0] slice_ctx;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [31:0] IMPL = 32'h000B_001F;
  localparam logic [31:0] SEVA = 32'h00E8_FCA8;
  localparam logic [31:0] SEVB = 32'h00AA_0000;
  int impl_list [8] = '{0, 1, 2, 3, 4, 16, 17, 19};

  always #5 clk = ~clk;

  lockstep_alarm_ctrl dut (
    .clk(clk), .rst(rst), .slice_mm(slice_mm), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .alarms(alarms),
    .state(state), .slice_ctx(slice_ctx), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse_mm(input logic [22:0] v);
    @(negedge clk); slice_mm = v;
    @(negedge clk); slice_mm = '0;
    @(negedge clk); @(negedge clk);
  endtask

  function automatic int sev_of(input int b);
    if (b < 12) return int'((SEVA >> (2*b)) & 3);
    return int'((SEVB >> (2*(b-12))) & 3);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    do_reset();

    // R1 reset state
    chk("R1 alarms", alarms, 0);
    chk("R1 state", {29'd0, state}, 32'h1);
    chk("R1 ctx", {9'd0, slice_ctx}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(6, d); chk("R1 maskA", d, 32'h555555);
    rd(7, d); chk("R1 maskB", d, 32'h555555);
    rd(8, d); chk("R1 sevA", d, SEVA);
    rd(9, d); chk("R1 sevB", d, SEVB);
    rd(11, d); chk("R1 rem", d, 2);
    rd(1, d); chk("R10 state read", d, 1);

    // R6 mismatch ignored while disabled
    pulse_mm(23'h20);
    chk("R6 ctx disabled", {9'd0, slice_ctx}, 0);
    chk("R6 alarms disabled", alarms, 0);

    // R2 enable -> operational
    wr(11, 0);
    chk("R2 state run", {29'd0, state}, 32'h2);

    // R6 slice sweep
    for (int i = 0; i < 23; i++) begin
      pulse_mm(23'(1) << i);
      chk("R6 ctx", {9'd0, slice_ctx}, (32'(1) << (i+1)) - 1);
      chk("R6 alarm0", alarms, 32'h1);
    end
    rd(2, d); chk("R10 ctx read", d, 32'h7FFFFF);

    // R3 injection sweep
    do_reset();
    wr(11, 0);
    for (int b = 0; b < 24; b++) begin
      wr(3, 32'(1) << b);
      chk("R3 inject", alarms, (32'(1) << b) & IMPL);
      wr(3, 0);
      chk("R3 clear", alarms, 0);
      chk("R3 state", {29'd0, state}, 32'h2);
    end

    // R8 severity and irq sweep
    for (int j = 0; j < 8; j++) begin
      for (int c = 0; c < 16; c++) begin
        int b;
        b = impl_list[j];
        wr(10, 32'(c));
        wr(3, 32'(1) << b);
        chk("R8 irq", {31'd0, irq}, 32'((c >> sev_of(b)) & 1));
        wr(3, 0);
        chk("R8 irq low", {31'd0, irq}, 0);
      end
    end
    wr(10, 0);

    // R7 mask code sweep
    for (int j = 0; j < 8; j++) begin
      for (int c = 0; c < 4; c++) begin
        int b;
        logic [31:0] mv, ex;
        b = impl_list[j];
        mv = 32'h555555;
        if (b < 12) begin
          mv[2*b +: 2] = 2'(c);
          wr(6, mv);
        end else begin
          mv[2*(b-12) +: 2] = 2'(c);
          wr(7, mv);
        end
        wr(3, 32'(1) << b);
        ex = 0;
        if (c == 1) ex[b] = 1'b1;
        if ((c == 0 || c == 3) && b != 19) ex[19] = 1'b1;
        chk("R7 mask", alarms, ex);
        wr(3, 0);
        wr(b < 12 ? 6 : 7, 32'h555555);
        chk("R7 restore", alarms, 0);
      end
    end

    // R4 root fault
    do_reset();
    wr(11, 0);
    wr(5, 23);
    wr(1 + 3, 1);
    chk("R4 bad select alarms", alarms, 0);
    chk("R4 bad select state", {29'd0, state}, 32'h2);
    wr(4, 0);
    wr(5, 4);
    wr(4, 1);
    chk("R4 root alarms", alarms, 32'h16);
    chk("R4 root state", {29'd0, state}, 32'h4);
    chk("R6 root no ctx", {9'd0, slice_ctx}, 0);
    // R5 sticky
    wr(4, 0);
    chk("R5 alarms kept", alarms, 32'h16);
    chk("R5 state kept", {29'd0, state}, 32'h4);
    pulse_mm(23'h3);
    chk("R6 ctx in fail", {9'd0, slice_ctx}, 0);
    wr(11, 0);
    chk("R2 fail stays", {29'd0, state}, 32'h4);
    do_reset();
    chk("R5 reset clears", alarms, 0);
    chk("R5 reset state", {29'd0, state}, 32'h1);

    // R9 enable budget
    for (int n = 1; n <= 5; n++) begin
      wr(11, 0);
      chk("R9 alarm17", alarms, (n >= 4) ? 32'h20000 : 32'h0);
      rd(11, d);
      chk("R9 remaining", d, (n >= 2) ? 0 : 32'(2 - n));
    end
    rd(0, d); chk("R10 alarm read", d, 32'h20000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule